// File: doc/BRIEF.md
# Wide Register Bus Collector

This block sits on the slave side of a host register bus whose beats are 32 or 64 bits wide. Behind it are control registers 128 bits wide and a buffer table of 64-bit entries. Software can only move a wide value in several beats, yet every wide value must change in one step. Every wide value must also be read as one consistent snapshot.

For writes, the block keeps the leading dwords of a wide register in a staging buffer. The beat that carries the final dword commits all 128 bits at once. For reads, the first dword of a wide register (or of a table entry) copies the whole value into a shadow. The following dwords are then served from that shadow, so a commit that lands between the beats cannot tear the result.

Three narrow 32-bit registers in every page bypass this mechanism. They are written directly, even in the middle of a wide write, and they leave the staging buffer untouched. The register space repeats in pages 0x2000 bytes apart. The buffer table sits directly above the last page.

Top module: `wreg_collector`

## Requirements
- R1: After reset every wide register, table entry and narrow register reads as zero, and `rdValid` is low until a read is issued.
- R2: A 32-bit write to dword 0, 1 or 2 (byte offset 0, 4 or 8) of a wide register only stages that dword, and the register keeps its old value. A 32-bit write to dword 3 (offset 12) commits {dw3, staged dw2, dw1, dw0}. Reads started after that write beat see the new value.
- R3: A 64-bit write at offset 0 of a wide register stages dwords 0 and 1 (data bits 31:0 and 63:32). A 64-bit write at offset 8 commits {wdata, staged dw1, staged dw0}.
- R4: A commit targets the register addressed by the final beat, using whatever dwords are staged, even if they were written for another register.
- R5: A read of dword 0 of a wide register (32-bit, or 64-bit at offset 0) returns live data and snapshots all 128 bits. Reads of dwords 1 to 3 (or a 64-bit read at offset 8, returning bits 127:64) return the snapshot even if the register has since changed.
- R6: Table entry i sits at byte 0x20000 + 8*i. A 32-bit write at offset 0 stages the low dword, and a 32-bit write at offset 4 commits {wdata, staged low dword}. A 64-bit write at offset 0 writes the whole entry. A read at offset 0 returns live data and snapshots the entry, and a read at offset 4 returns the snapshot's upper dword.
- R7: Narrow registers k = 0, 1, 2 sit at page offset 0x40 + 16*k (dword 0 only). A write there takes effect at once, a read returns live data, and neither disturbs the staging buffer.
- R8: Page p (0 to 15) occupies bytes p*0x2000 up to p*0x2000 + 0x1FFF. Wide register s (0 to 3) sits at page offset 16*s. Pages are independent.
- R9: Read data appears on `rdata`, with `rdValid` high for one cycle, on the cycle after `rdEn`. If `wrEn` and `rdEn` are both high, only the write is done and no read data is returned.
- R10: The following accesses change no state and read as zero: an address with bits 1:0 non-zero, a 64-bit access with address bit 2 set, and an address outside the mapped registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write beat strobe |
| rdEn | input | 1 | Read beat strobe |
| wide64 | input | 1 | 1: 64-bit beat, 0: 32-bit beat |
| addr | input | 18 | Byte address |
| wdata | input | 64 | Write data (bits 31:0 used by 32-bit beats) |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| rdata | output | 64 | Read data (upper half zero for 32-bit reads) |

## Verification
The assertions check, on every cycle, that the shadow changes only on a snapshot beat and that a narrow write leaves the staging buffer untouched. They also check that at most one kind of write commit is decoded per beat, and that misaligned addresses raise no strobe. Whether the correct 128 bits arrive at the correct register can only be shown by the bench scenarios. The same holds for a commit redirected to another register, for stale shadow data after an interleaved commit, and for narrow writes landing in the middle of a wide sequence. The bench checks these against a reference model driven by random and directed traffic.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  typedef enum logic [2:0] {
    SRC_NONE, SRC_WIDE, SRC_BT, SRC_SHADOW, SRC_NARROW
  } rdSrc_e;

  typedef struct packed {
    logic [3:0] stageEn;
    logic       commitWide;
    logic       commitBt;
    logic       narrowWr;
    logic       snapWide;
    logic       snapBt;
    logic       rdLoad;
    logic       wide64;
    rdSrc_e     rdSrc;
    logic [1:0] wordSel;
  } strobe_t;
endpackage

// File: rtl/wrc_ctrl.sv
module wrc_ctrl import wrc_pkg::*; #(
  parameter int PAGES     = 16,
  parameter int WREGS     = 4,
  parameter int NARROW    = 3,
  parameter int BT_DEPTH  = 64,
  parameter int PAGE_SPAN = 13,
  localparam int PG_W   = $clog2(PAGES),
  localparam int BT_W   = $clog2(BT_DEPTH),
  localparam int ADDR_W = PAGE_SPAN + PG_W + 1,
  localparam int WI_W   = $clog2(PAGES * WREGS),
  localparam int NI_W   = $clog2(PAGES * NARROW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              wide64,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           st,
  output logic [WI_W-1:0]   wideIdx,
  output logic [BT_W-1:0]   btIdx,
  output logic [NI_W-1:0]   narrowIdx
);
  localparam logic [2:0] NAR_LO = 3'(WREGS);
  localparam logic [2:0] NAR_HI = 3'(WREGS + NARROW);

  logic [PG_W-1:0] pg;
  logic [2:0]      slot;
  logic [1:0]      dw;
  logic            alignOk, inPage, isWide, isNar, isBt, btHi, rdGo;

  always_comb begin
    pg      = addr[PAGE_SPAN +: PG_W];
    slot    = addr[6:4];
    dw      = addr[3:2];
    btHi    = addr[2];
    alignOk = (addr[1:0] == 2'b00) && !(wide64 && addr[2]);
    inPage  = !addr[ADDR_W-1] && (addr[PAGE_SPAN-1:7] == '0) && alignOk;
    isWide  = inPage && (slot < NAR_LO);
    isNar   = inPage && (slot >= NAR_LO) && (slot < NAR_HI) && (dw == 2'd0);
    isBt    = addr[ADDR_W-1] && (addr[ADDR_W-2:BT_W+3] == '0) && alignOk;
    wideIdx   = WI_W'(pg) * WI_W'(WREGS) + WI_W'(slot);
    narrowIdx = NI_W'(pg) * NI_W'(NARROW) + NI_W'(slot - NAR_LO);
    btIdx     = addr[BT_W+2:3];
    rdGo      = rdEn && !wrEn;

    st = '0;
    st.wide64 = wide64;
    st.rdLoad = rdGo;
    st.rdSrc  = SRC_NONE;
    if (wrEn) begin
      if (isWide) begin
        if (wide64) begin
          if (dw == 2'd0) st.stageEn = 4'b0011;
          else            st.commitWide = 1'b1;
        end else if (dw == 2'd3) begin
          st.commitWide = 1'b1;
        end else begin
          st.stageEn = 4'b0001 << dw;
        end
      end else if (isBt) begin
        if (!wide64 && !btHi) st.stageEn = 4'b0001;
        else                  st.commitBt = 1'b1;
      end else if (isNar) begin
        st.narrowWr = 1'b1;
      end
    end
    if (rdGo) begin
      if (isWide) begin
        if (dw == 2'd0) begin
          st.rdSrc = SRC_WIDE;
          st.snapWide = 1'b1;
        end else begin
          st.rdSrc = SRC_SHADOW;
          st.wordSel = dw;
        end
      end else if (isBt) begin
        if (!btHi) begin
          st.rdSrc = SRC_BT;
          st.snapBt = 1'b1;
        end else begin
          st.rdSrc = SRC_SHADOW;
          st.wordSel = 2'd1;
        end
      end else if (isNar) begin
        st.rdSrc = SRC_NARROW;
      end
    end
  end

  // R2 / R6 / R7: a beat commits or writes at most one kind of target
  a_r2_single_commit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.commitWide, st.commitBt, st.narrowWr}));

  // R10: misaligned addresses raise no strobe at all
  a_r10_misaligned_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (addr[1:0] != 2'b00) |-> (st.stageEn == 4'b0 && !st.commitWide &&
      !st.commitBt && !st.narrowWr && !st.snapWide && !st.snapBt));

  // R9: with no write beat, no write strobe may appear
  a_r9_no_stray_write: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (st.stageEn == 4'b0 && !st.commitWide && !st.commitBt && !st.narrowWr));
endmodule

// File: rtl/wrc_datapath.sv
module wrc_datapath import wrc_pkg::*; #(
  parameter int PAGES    = 16,
  parameter int WREGS    = 4,
  parameter int NARROW   = 3,
  parameter int BT_DEPTH = 64,
  localparam int NWIDE = PAGES * WREGS,
  localparam int NNAR  = PAGES * NARROW,
  localparam int BT_W  = $clog2(BT_DEPTH),
  localparam int WI_W  = $clog2(NWIDE),
  localparam int NI_W  = $clog2(NNAR)
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         st,
  input  logic [WI_W-1:0] wideIdx,
  input  logic [BT_W-1:0] btIdx,
  input  logic [NI_W-1:0] narrowIdx,
  input  logic [63:0]     wdata,
  output logic            rdValid,
  output logic [63:0]     rdata
);
  logic [3:0][31:0] stage;
  logic [127:0]     wideMem [NWIDE];
  logic [63:0]      btMem   [BT_DEPTH];
  logic [31:0]      narMem  [NNAR];
  logic [127:0]     shadow;
  logic [127:0]     commitVal;
  logic [63:0]      btVal, hiHalf, rdNext;

  for (genvar k = 0; k < 4; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN)              stage[k] <= '0;
      else if (st.stageEn[k]) stage[k] <= st.wide64 ? wdata[32*(k%2) +: 32] : wdata[31:0];
    end
  end

  always_comb begin
    hiHalf    = st.wide64 ? wdata : {wdata[31:0], stage[2]};
    commitVal = {hiHalf, stage[1], stage[0]};
    btVal     = st.wide64 ? wdata : {wdata[31:0], stage[0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NWIDE; i++)    wideMem[i] <= '0;
      for (int i = 0; i < BT_DEPTH; i++) btMem[i]   <= '0;
      for (int i = 0; i < NNAR; i++)     narMem[i]  <= '0;
    end else begin
      if (st.commitWide) wideMem[wideIdx] <= commitVal;
      if (st.commitBt)   btMem[btIdx]     <= btVal;
      if (st.narrowWr)   narMem[narrowIdx] <= wdata[31:0];
    end
  end

  always_comb begin
    unique case (st.rdSrc)
      SRC_WIDE:   rdNext = st.wide64 ? wideMem[wideIdx][63:0] : {32'b0, wideMem[wideIdx][31:0]};
      SRC_BT:     rdNext = st.wide64 ? btMem[btIdx] : {32'b0, btMem[btIdx][31:0]};
      SRC_SHADOW: rdNext = st.wide64 ? shadow[64*st.wordSel[1] +: 64]
                                     : {32'b0, shadow[32*st.wordSel +: 32]};
      SRC_NARROW: rdNext = {32'b0, narMem[narrowIdx]};
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow  <= '0;
      rdata   <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= st.rdLoad;
      if (st.rdLoad) rdata <= rdNext;
      if (st.snapWide)    shadow <= wideMem[wideIdx];
      else if (st.snapBt) shadow <= {64'b0, btMem[btIdx]};
    end
  end

  // R5: the shadow only moves on a snapshot beat
  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(st.snapWide || st.snapBt) |=> $stable(shadow));

  // R7: a narrow write leaves the staging buffer as it was
  a_r7_stage_untouched: assert property (@(posedge clk) disable iff (!rstN)
    st.narrowWr |=> $stable(stage));
endmodule

// File: rtl/wreg_collector.sv
module wreg_collector import wrc_pkg::*; #(
  parameter int PAGES     = 16,
  parameter int WREGS     = 4,
  parameter int NARROW    = 3,
  parameter int BT_DEPTH  = 64,
  parameter int PAGE_SPAN = 13,
  localparam int PG_W   = $clog2(PAGES),
  localparam int BT_W   = $clog2(BT_DEPTH),
  localparam int ADDR_W = PAGE_SPAN + PG_W + 1,
  localparam int WI_W   = $clog2(PAGES * WREGS),
  localparam int NI_W   = $clog2(PAGES * NARROW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              wide64,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       wdata,
  output logic              rdValid,
  output logic [63:0]       rdata
);
  strobe_t         st;
  logic [WI_W-1:0] wideIdx;
  logic [BT_W-1:0] btIdx;
  logic [NI_W-1:0] narrowIdx;

  wrc_ctrl #(.PAGES(PAGES), .WREGS(WREGS), .NARROW(NARROW),
             .BT_DEPTH(BT_DEPTH), .PAGE_SPAN(PAGE_SPAN)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wide64(wide64),
    .addr(addr), .st(st), .wideIdx(wideIdx), .btIdx(btIdx), .narrowIdx(narrowIdx));

  wrc_datapath #(.PAGES(PAGES), .WREGS(WREGS), .NARROW(NARROW),
                 .BT_DEPTH(BT_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wideIdx(wideIdx), .btIdx(btIdx),
    .narrowIdx(narrowIdx), .wdata(wdata), .rdValid(rdValid), .rdata(rdata));
endmodule

// File: tb/wreg_collector_tb.sv
module wreg_collector_tb;
  logic        clk = 0, rstN = 0, wrEn = 0, rdEn = 0, wide64 = 0;
  logic [17:0] addr = '0;
  logic [63:0] wdata = '0;
  logic        rdValid;
  logic [63:0] rdata;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  wreg_collector u_dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .wide64(wide64), .addr(addr), .wdata(wdata), .rdValid(rdValid), .rdata(rdata));

  // reference model
  logic [127:0] wm [64];
  logic [63:0]  bm [64];
  logic [31:0]  nm [48];
  logic [31:0]  sm [4];
  logic [127:0] sh;

  function automatic int decode(input logic w64, input logic [17:0] a,
      output int wi, output int bi, output int ni, output int dw, output bit hi);
    int pg, slot;
    wi = 0; bi = 0; ni = 0; dw = 0; hi = 0;
    if (a[1:0] != 0 || (w64 && a[2])) return 0;
    if (a[17]) begin
      if (a[16:9] != 0) return 0;
      bi = int'(a[8:3]); hi = a[2]; return 2;
    end
    if (a[12:7] != 0) return 0;
    pg = int'(a[16:13]); slot = int'(a[6:4]); dw = int'(a[3:2]);
    if (slot < 4) begin wi = pg*4 + slot; return 1; end
    if (slot < 7 && dw == 0) begin ni = pg*3 + slot - 4; return 3; end
    return 0;
  endfunction

  function automatic void modelWr(input logic w64, input logic [17:0] a, input logic [63:0] d);
    int wi, bi, ni, dw; bit hi; int k;
    k = decode(w64, a, wi, bi, ni, dw, hi);
    if (k == 1) begin
      if (w64) begin
        if (dw == 0) begin sm[0] = d[31:0]; sm[1] = d[63:32]; end
        else wm[wi] = {d, sm[1], sm[0]};
      end else if (dw < 3) sm[dw] = d[31:0];
      else wm[wi] = {d[31:0], sm[2], sm[1], sm[0]};
    end else if (k == 2) begin
      if (w64) bm[bi] = d;
      else if (!hi) sm[0] = d[31:0];
      else bm[bi] = {d[31:0], sm[0]};
    end else if (k == 3) nm[ni] = d[31:0];
  endfunction

  function automatic logic [63:0] modelRd(input logic w64, input logic [17:0] a);
    int wi, bi, ni, dw; bit hi; int k;
    k = decode(w64, a, wi, bi, ni, dw, hi);
    if (k == 1) begin
      if (dw == 0) begin sh = wm[wi]; return w64 ? wm[wi][63:0] : {32'b0, wm[wi][31:0]}; end
      return w64 ? sh[127:64] : {32'b0, sh[32*dw +: 32]};
    end
    if (k == 2) begin
      if (!hi) begin sh = {64'b0, bm[bi]}; return w64 ? bm[bi] : {32'b0, bm[bi][31:0]}; end
      return {32'b0, sh[63:32]};
    end
    if (k == 3) return {32'b0, nm[ni]};
    return 64'b0;
  endfunction

  function automatic logic [17:0] wA(int p, int s, int dw); return 18'(p*32'h2000 + s*16 + dw*4); endfunction
  function automatic logic [17:0] nA(int p, int k);         return 18'(p*32'h2000 + (4+k)*16); endfunction
  function automatic logic [17:0] bA(int i, int hi);        return 18'(32'h20000 + i*8 + hi*4); endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic w64, input logic [17:0] a, input logic [63:0] d);
    wrEn = 1; wide64 = w64; addr = a; wdata = d;
    modelWr(w64, a, d);
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rd(input string req, input logic w64, input logic [17:0] a);
    logic [63:0] e;
    rdEn = 1; wide64 = w64; addr = a;
    e = modelRd(w64, a);
    @(negedge clk);
    rdEn = 0;
    check({req, " valid"}, 64'(rdValid), 64'd1);
    check(req, rdata, e);
  endtask

  task automatic rdWide(input string req, input int p, input int s);
    for (int d = 0; d < 4; d++) rd(req, 1'b0, wA(p, s, d));
  endtask

  initial begin
    fork
      begin
        #(2_000_000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    void'($urandom(32'h0C0FFEE5));
    for (int i = 0; i < 64; i++) begin wm[i] = '0; bm[i] = '0; end
    for (int i = 0; i < 48; i++) nm[i] = '0;
    for (int i = 0; i < 4; i++)  sm[i] = '0;
    sh = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    check("R1 rdValid idle", 64'(rdValid), 64'd0);
    rdWide("R1 wide zero", 5, 3);
    rd("R1 table zero", 1'b1, bA(63, 0));
    rd("R1 narrow zero", 1'b0, nA(15, 2));

    // R2: staged dwords stay invisible until dw3
    wr(1'b0, wA(1, 2, 0), 64'h11111111);
    wr(1'b0, wA(1, 2, 1), 64'h22222222);
    wr(1'b0, wA(1, 2, 2), 64'h33333333);
    rdWide("R2 before commit", 1, 2);
    wr(1'b0, wA(1, 2, 3), 64'h44444444);
    rd("R2 after commit", 1'b0, wA(1, 2, 0));
    check("R2 literal dw0", rdata, 64'h11111111);
    rd("R2 dw3", 1'b0, wA(1, 2, 3));
    check("R2 literal dw3", rdata, 64'h44444444);

    // R3: 64-bit beats
    wr(1'b1, wA(0, 1, 0), 64'hAAAA0001_BBBB0002);
    rd("R3 before commit", 1'b1, wA(0, 1, 0));
    wr(1'b1, wA(0, 1, 2), 64'hCCCC0003_DDDD0004);
    rd("R3 low", 1'b1, wA(0, 1, 0));
    check("R3 literal low", rdata, 64'hAAAA0001_BBBB0002);
    rd("R3 high", 1'b1, wA(0, 1, 2));
    check("R3 literal high", rdata, 64'hCCCC0003_DDDD0004);

    // R4: commit goes to the final beat's register
    wr(1'b0, wA(2, 0, 0), 64'h0A0A0A0A);
    wr(1'b0, wA(2, 0, 1), 64'h0B0B0B0B);
    wr(1'b0, wA(2, 0, 2), 64'h0C0C0C0C);
    wr(1'b0, wA(3, 1, 3), 64'h0D0D0D0D);
    rdWide("R4 redirected", 3, 1);
    rdWide("R4 untouched", 2, 0);

    // R5: shadow stays stale across a commit
    rd("R5 snap", 1'b0, wA(1, 2, 0));
    wr(1'b1, wA(1, 2, 0), 64'h55555555_66666666);
    wr(1'b1, wA(1, 2, 2), 64'h77777777_88888888);
    rd("R5 stale dw1", 1'b0, wA(1, 2, 1));
    check("R5 literal stale", rdata, 64'h22222222);
    rd("R5 stale hi", 1'b1, wA(1, 2, 2));
    rdWide("R5 resnap", 1, 2);

    // R6: buffer table
    wr(1'b0, bA(7, 0), 64'h12345678);
    rd("R6 before commit", 1'b1, bA(7, 0));
    wr(1'b0, bA(7, 1), 64'h9ABCDEF0);
    rd("R6 lo snap", 1'b0, bA(7, 0));
    wr(1'b1, bA(7, 0), 64'h0);
    rd("R6 upper from shadow", 1'b0, bA(7, 1));
    check("R6 literal upper", rdata, 64'h9ABCDEF0);
    wr(1'b1, bA(8, 0), 64'hFEEDFACE_CAFEF00D);
    rd("R6 whole", 1'b1, bA(8, 0));

    // R7: narrow writes interleaved with a wide write
    wr(1'b0, wA(4, 3, 0), 64'hD0D0D0D0);
    wr(1'b0, nA(4, 0), 64'hE0E0E0E0);
    wr(1'b0, wA(4, 3, 1), 64'hD1D1D1D1);
    wr(1'b0, nA(4, 1), 64'hE1E1E1E1);
    wr(1'b0, wA(4, 3, 2), 64'hD2D2D2D2);
    wr(1'b0, nA(4, 2), 64'hE2E2E2E2);
    wr(1'b0, wA(4, 3, 3), 64'hD3D3D3D3);
    rdWide("R7 wide intact", 4, 3);
    rd("R7 narrow live", 1'b0, nA(4, 1));
    check("R7 literal narrow", rdata, 64'hE1E1E1E1);

    // R8: same slot, different pages
    wr(1'b1, wA(9, 0, 0), 64'h1);
    wr(1'b1, wA(9, 0, 2), 64'h2);
    rdWide("R8 page 9", 9, 0);
    rdWide("R8 page 10", 10, 0);

    // R9: write wins over a simultaneous read
    rdEn = 1;
    wr(1'b0, nA(6, 0), 64'h6A6A6A6A);
    rdEn = 0;
    check("R9 no read data", 64'(rdValid), 64'd0);
    rd("R9 write done", 1'b0, nA(6, 0));

    // R10: unmapped and misaligned accesses
    wr(1'b0, 18'(32'h2000 + 32'h80), 64'hBAD0BAD0);
    rd("R10 unmapped read", 1'b0, 18'(32'h2000 + 32'h80));
    wr(1'b1, wA(5, 0, 1), 64'hBADBADBA_DBADBAD0);
    wr(1'b0, 18'(wA(5, 0, 0) + 1), 64'hBAD1);
    rd("R10 misaligned read", 1'b1, wA(5, 0, 1));
    rdWide("R10 no change", 5, 0);
    rd("R10 narrow dw1", 1'b0, 18'(nA(5, 0) + 4));

    // random mix against the model
    for (int n = 0; n < 600; n++) begin
      int p, s, op;
      logic [63:0] d;
      p = int'($urandom % 16); s = int'($urandom % 4); op = int'($urandom % 9);
      d = {$urandom, $urandom};
      case (op)
        0: wr(1'b0, wA(p, s, int'($urandom % 4)), d);
        1: wr(1'b1, wA(p, s, 2 * int'($urandom % 2)), d);
        2: wr(1'b0, nA(p, int'($urandom % 3)), d);
        3: wr($urandom % 2 == 1, bA(int'($urandom % 64), 0), d);
        4: wr(1'b0, bA(int'($urandom % 64), 1), d);
        5: rd("R2 R5 random", 1'b0, wA(p, s, int'($urandom % 4)));
        6: rd("R3 R5 random", 1'b1, wA(p, s, 2 * int'($urandom % 2)));
        7: rd("R6 random", $urandom % 2 == 1, bA(int'($urandom % 64), 0));
        default: rd("R7 R8 random", 1'b0, nA(p, int'($urandom % 3)));
      endcase
    end
    for (int q = 0; q < 16; q++) rdWide("R8 sweep", q, q % 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule